// File: doc/BRIEF.md
# Secure World Configuration Register

This block holds the control word that a processor with a secure and a non-secure world uses to decide where it is running, where three classes of exception are taken, and whether non-secure code may alter the abort and fast-interrupt mask bits of its status register. Software reaches it through a coprocessor register access port. That port carries a four-field selector (opcode1, CRn, CRm, opcode2), a valid strobe with a read/write flag, write data, and the current processor mode.

Only a secure privileged mode may touch the word. Any other access that hits the selector raises an undefined-instruction request and leaves the contents unchanged. From the stored bits and the current mode the block drives several combinational outputs: the effective security state, the bank select for banked registers, three routing decisions (own handler or monitor), two write enables for the status mask bits, and a warning flag for setting pairs known to be hazardous.

Top module: `sec_cfg_reg`

## Requirements
- R1: The register is selected only when opcode1=0, CRn=1, CRm=1 and opcode2=0, for reads and writes alike. An access with any other selector changes nothing, raises no undefined request and reads zero.
- R2: Field positions: bit0 world (0 secure, 1 non-secure), bit1 IRQ route, bit2 FIQ route, bit3 external-abort route, bit4 F-write allow, bit5 A-write allow. Bits 31:6 read as zero and writes to them are dropped.
- R3: After reset the register holds zero, so the secure world is in force, all three exceptions are handled locally and both mask write enables are high.
- R4: An access is allowed only when the mode is not user (5'h10) and either bit0 is 0 or the mode is monitor (5'h16). A selected access that is not allowed asserts acc_undef in the same cycle, does not change the register and reads zero.
- R5: eff_secure is 1 whenever the mode is monitor (5'h16), and otherwise equals the inverse of bit0.
- R6: bank_nonsecure equals bit0 in every mode, so monitor mode with bit0=1 selects the non-secure copies.
- R7: For IRQ, FIQ and external abort, the matching route output is 1 (monitor) when its routing bit is 1 and 0 (own handler mode) when it is 0.
- R8: When eff_secure is 0, f_write_en equals bit4 and a_write_en equals bit5. When eff_secure is 1, both are 1.
- R9: An allowed write is visible on the outputs in the cycle after the clock edge that accepts it. Read data is driven combinationally in the same cycle as the read strobe.
- R10: cfg_hazard is 1 exactly when bit4 equals bit2, or when bit5 equals bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Coprocessor access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_op1 | input | 3 | Selector opcode1 |
| acc_crn | input | 4 | Selector CRn |
| acc_crm | input | 4 | Selector CRm |
| acc_op2 | input | 3 | Selector opcode2 |
| acc_wdata | input | 32 | Write data |
| cpu_mode | input | 5 | Current processor mode |
| acc_rdata | output | 32 | Read data, zero unless an allowed read hits |
| acc_undef | output | 1 | Undefined-instruction request |
| eff_secure | output | 1 | Effective security state, 1 = secure |
| bank_nonsecure | output | 1 | Selects the non-secure copies of banked registers |
| route_irq_mon | output | 1 | IRQ taken in monitor mode |
| route_fiq_mon | output | 1 | FIQ taken in monitor mode |
| route_abt_mon | output | 1 | External abort taken in monitor mode |
| f_write_en | output | 1 | Status F bit may be written |
| a_write_en | output | 1 | Status A bit may be written |
| cfg_hazard | output | 1 | Hazardous setting pair present |

## Verification
acc_undef and acc_rdata are combinational and due in the cycle the strobe is driven, so the bench drives on the falling edge and samples them one nanosecond later, before the rising edge. A write becomes visible only after the next rising edge, so routing, bank select, write enables and the hazard flag are sampled after the strobe has been withdrawn on the following falling edge. The same outputs are also sampled in the write cycle to confirm they still show the old value. Mode-only effects (effective state, write enables) need no edge, so the bench changes cpu_mode and samples after a short settle delay.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;
   localparam int unsigned CFG_W   = 6;
   localparam int unsigned B_WORLD = 0;
   localparam int unsigned B_IRQ   = 1;
   localparam int unsigned B_FIQ   = 2;
   localparam int unsigned B_ABT   = 3;
   localparam int unsigned B_FALW  = 4;
   localparam int unsigned B_AALW  = 5;
   localparam int unsigned N_ROUTE = 3;

   localparam logic [4:0] MODE_USER = 5'h10;
   localparam logic [4:0] MODE_MON  = 5'h16;

   typedef struct packed {
      logic [N_ROUTE-1:0] to_mon;
   } route_t;
endpackage

// File: rtl/sec_cfg_decode.sv
module sec_cfg_decode #(
   parameter logic [2:0] SEL_OP1 = 3'd0,
   parameter logic [3:0] SEL_CRN = 4'd1,
   parameter logic [3:0] SEL_CRM = 4'd1,
   parameter logic [2:0] SEL_OP2 = 3'd0
) (
   input  logic       valid,
   input  logic       write,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   input  logic [4:0] mode,
   input  logic       world_ns,
   output logic       rd_ok,
   output logic       wr_ok,
   output logic       undef
);
   import sec_cfg_pkg::*;

   logic hit;
   logic allowed;

   always_comb begin
      hit     = valid && (op1 == SEL_OP1) && (crn == SEL_CRN)
                && (crm == SEL_CRM) && (op2 == SEL_OP2);
      allowed = (mode != MODE_USER) && (!world_ns || (mode == MODE_MON));
      rd_ok   = hit && allowed && !write;
      wr_ok   = hit && allowed && write;
      undef   = hit && !allowed;
   end
endmodule

// File: rtl/sec_cfg_store.sv
module sec_cfg_store #(
   parameter int unsigned W         = 6,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RESET_VAL;
      else if (wr_en) q <= wdata;
   end
endmodule

// File: rtl/sec_cfg_policy.sv
module sec_cfg_policy
   import sec_cfg_pkg::*;
#(
   parameter int unsigned W = CFG_W
) (
   input  logic [W-1:0] cfg,
   input  logic [4:0]   mode,
   output logic         secure,
   output logic         bank_ns,
   output route_t       route,
   output logic         f_we,
   output logic         a_we,
   output logic         hazard
);
   always_comb begin
      secure  = !cfg[B_WORLD] || (mode == MODE_MON);
      bank_ns = cfg[B_WORLD];
      f_we    = secure || cfg[B_FALW];
      a_we    = secure || cfg[B_AALW];
      hazard  = (cfg[B_FALW] == cfg[B_FIQ]) || (cfg[B_AALW] == cfg[B_ABT]);
   end

   for (genvar i = 0; i < N_ROUTE; i++) begin : g_route
      assign route.to_mon[i] = cfg[B_IRQ + i];
   end
endmodule

// File: rtl/sec_cfg_reg.sv
module sec_cfg_reg
   import sec_cfg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IMPL_W    = CFG_W,
   parameter logic [IMPL_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_op1,
   input  logic [3:0]        acc_crn,
   input  logic [3:0]        acc_crm,
   input  logic [2:0]        acc_op2,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [4:0]        cpu_mode,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_undef,
   output logic              eff_secure,
   output logic              bank_nonsecure,
   output logic              route_irq_mon,
   output logic              route_fiq_mon,
   output logic              route_abt_mon,
   output logic              f_write_en,
   output logic              a_write_en,
   output logic              cfg_hazard
);
   localparam int unsigned PAD_W = DATA_W - IMPL_W;

   if (IMPL_W != CFG_W) begin : g_bad_impl
      $error("IMPL_W must equal the field count");
   end
   if (DATA_W <= IMPL_W) begin : g_bad_data
      $error("DATA_W must exceed IMPL_W");
   end

   logic              rd_ok;
   logic              wr_ok;
   logic [IMPL_W-1:0] cfg_q;
   route_t            route;

   sec_cfg_decode u_dec (
      .valid    (acc_valid),
      .write    (acc_write),
      .op1      (acc_op1),
      .crn      (acc_crn),
      .crm      (acc_crm),
      .op2      (acc_op2),
      .mode     (cpu_mode),
      .world_ns (cfg_q[B_WORLD]),
      .rd_ok    (rd_ok),
      .wr_ok    (wr_ok),
      .undef    (acc_undef)
   );

   sec_cfg_store #(.W(IMPL_W), .RESET_VAL(RESET_VAL)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_ok),
      .wdata (acc_wdata[IMPL_W-1:0]),
      .q     (cfg_q)
   );

   sec_cfg_policy #(.W(IMPL_W)) u_pol (
      .cfg     (cfg_q),
      .mode    (cpu_mode),
      .secure  (eff_secure),
      .bank_ns (bank_nonsecure),
      .route   (route),
      .f_we    (f_write_en),
      .a_we    (a_write_en),
      .hazard  (cfg_hazard)
   );

   assign route_irq_mon = route.to_mon[0];
   assign route_fiq_mon = route.to_mon[1];
   assign route_abt_mon = route.to_mon[2];
   assign acc_rdata     = rd_ok ? {{PAD_W{1'b0}}, cfg_q} : '0;
endmodule

// File: rtl/sec_cfg_chk.sv
module sec_cfg_chk
   import sec_cfg_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_write,
   input logic [2:0]  acc_op1,
   input logic [3:0]  acc_crn,
   input logic [3:0]  acc_crm,
   input logic [2:0]  acc_op2,
   input logic [31:0] acc_wdata,
   input logic [31:0] acc_rdata,
   input logic [4:0]  cpu_mode,
   input logic        acc_undef,
   input logic        eff_secure,
   input logic        bank_nonsecure,
   input logic        route_irq_mon,
   input logic        f_write_en,
   input logic        a_write_en,
   input logic [5:0]  cfg_q
);
   logic sel;
   assign sel = (acc_op1 == 3'd0) && (acc_crn == 4'd1) && (acc_crm == 4'd1) && (acc_op2 == 3'd0);

   // R1
   r1_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !acc_undef && (acc_rdata == '0));
   // R2
   r2_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdata[31:6] == '0);
   // R4
   r4_undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_undef |=> $stable(cfg_q));
   // R4
   r4_user_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && sel && cpu_mode == MODE_USER) |-> acc_undef);
   // R5
   r5_mon_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_mode == MODE_MON) |-> eff_secure);
   // R6
   r6_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_nonsecure == cfg_q[0]);
   // R7
   r7_irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_irq_mon == cfg_q[1]);
   // R8
   r8_secure_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eff_secure |-> f_write_en && a_write_en);
   // R9
   r9_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && sel && !acc_undef) |=> cfg_q == $past(acc_wdata[5:0]));
endmodule

bind sec_cfg_reg sec_cfg_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .acc_valid      (acc_valid),
   .acc_write      (acc_write),
   .acc_op1        (acc_op1),
   .acc_crn        (acc_crn),
   .acc_crm        (acc_crm),
   .acc_op2        (acc_op2),
   .acc_wdata      (acc_wdata),
   .acc_rdata      (acc_rdata),
   .cpu_mode       (cpu_mode),
   .acc_undef      (acc_undef),
   .eff_secure     (eff_secure),
   .bank_nonsecure (bank_nonsecure),
   .route_irq_mon  (route_irq_mon),
   .f_write_en     (f_write_en),
   .a_write_en     (a_write_en),
   .cfg_q          (cfg_q)
);

// File: tb/tb_sec_cfg_reg.sv
`timescale 1ns/1ps
module tb_sec_cfg_reg;
   localparam logic [4:0] USR = 5'h10, SVC = 5'h13, MON = 5'h16;

   logic        clk = 0, rst_n = 0;
   logic        acc_valid = 0, acc_write = 0;
   logic [2:0]  acc_op1 = 0, acc_op2 = 0;
   logic [3:0]  acc_crn = 1, acc_crm = 1;
   logic [31:0] acc_wdata = 0;
   logic [4:0]  cpu_mode = MON;
   logic [31:0] acc_rdata;
   logic acc_undef, eff_secure, bank_nonsecure, route_irq_mon, route_fiq_mon,
         route_abt_mon, f_write_en, a_write_en, cfg_hazard;

   int total = 0, bad = 0;
   logic        s_undef;
   logic [31:0] s_rdata;

   sec_cfg_reg dut (.*);

   always #2.5 clk = ~clk;

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic wr, input logic [3:0] crm, input logic [31:0] d,
                      input logic [4:0] md);
      @(negedge clk);
      acc_valid = 1; acc_write = wr; acc_crm = crm; acc_wdata = d; cpu_mode = md;
      #1;
      s_undef = acc_undef; s_rdata = acc_rdata;
      @(negedge clk);
      acc_valid = 0; acc_write = 0; acc_crm = 1;
      #1;
   endtask

   task automatic rd_mon(output logic [31:0] v);
      acc(0, 4'd1, 0, MON);
      v = s_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R3 reset state
      rd_mon(v);
      chk("R3 reset value", v, 0);
      cpu_mode = SVC; #1;
      chk("R3 reset outputs", {eff_secure, bank_nonsecure, route_irq_mon, route_fiq_mon,
          route_abt_mon, f_write_en, a_write_en}, 7'b1000011);

      // sweep all field values through monitor mode
      for (int k = 0; k < 64; k++) begin
         logic [5:0] f;
         logic sec;
         f = 6'(k);
         acc(1, 4'd1, {26'h2AAAAAA ^ 26'(k * 7), f}, MON);
         chk("R4 monitor write no undef", s_undef, 0);
         rd_mon(v);
         chk("R2 readback and pad", v, {26'd0, f});
         chk("R7 routing", {route_abt_mon, route_fiq_mon, route_irq_mon}, f[3:1]);
         chk("R6 bank in monitor", bank_nonsecure, f[0]);
         chk("R5 monitor secure", eff_secure, 1);
         chk("R10 hazard", cfg_hazard, (f[4] == f[2]) || (f[5] == f[3]));
         cpu_mode = SVC; #1;
         sec = !f[0];
         chk("R5 svc state", eff_secure, sec);
         chk("R6 bank in svc", bank_nonsecure, f[0]);
         chk("R8 f enable", f_write_en, sec | f[4]);
         chk("R8 a enable", a_write_en, sec | f[5]);
      end

      // mode/world permission sweep
      for (int m = 0; m < 32; m++) begin
         for (int ns = 0; ns < 2; ns++) begin
            logic ok;
            logic [31:0] x;
            acc(1, 4'd1, 32'(ns), MON);
            ok = (5'(m) != USR) && (ns == 0 || 5'(m) == MON);
            x = 32'h0000_000A | 32'(ns);
            acc(1, 4'd1, x, 5'(m));
            chk("R4 write undef", s_undef, !ok);
            rd_mon(v);
            chk("R4 write effect", v, ok ? x : 32'(ns));
            acc(0, 4'd1, 0, 5'(m));
            chk("R4 read undef", s_undef, !ok);
            chk("R4 read data", s_rdata, ok ? x : 0);
         end
      end

      // R1 other selectors ignored
      acc(1, 4'd1, 32'h0, MON);
      for (int c = 0; c < 16; c++) begin
         if (c == 1) continue;
         acc(1, 4'(c), 32'h3F, USR);
         chk("R1 no undef off-select", s_undef, 0);
         acc(0, 4'(c), 0, MON);
         chk("R1 zero read off-select", s_rdata, 0);
      end
      rd_mon(v);
      chk("R1 unchanged after off-select", v, 0);

      // R9 timing: old value until edge, read same cycle
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_wdata = 32'h0E; cpu_mode = MON;
      #1;
      chk("R9 old routing before edge", {route_abt_mon, route_fiq_mon, route_irq_mon}, 0);
      @(posedge clk); #1;
      chk("R9 new routing after edge", {route_abt_mon, route_fiq_mon, route_irq_mon}, 3'b111);
      @(negedge clk);
      acc_write = 0; #1;
      chk("R9 same-cycle read", acc_rdata, 32'h0E);
      @(negedge clk);
      acc_valid = 0; #1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule